// File: doc/BRIEF.md
# Multi-Mode Up/Down Timer Channel with Toggle Latch

This block is one 16-bit timer/counter channel paired with a 16-bit auxiliary counter. The core counter runs in one of three modes. In timer mode it steps on ticks from a prescaler, whose shortest period is 8 system clocks. In gated mode it steps on those same ticks, but only while an external input sits at a chosen level, which lets software measure pulse widths and duty cycles. In counter mode it steps on chosen edges of that external input. The count direction comes from a software bit. An external direction pin can reverse it when that pin is enabled.

Each time the core counter overflows or underflows, a toggle latch flips. The latch can drive an output pin. Latch transitions can also clock the auxiliary counter, so the pair forms one 32-bit count, or 33 bits if the latch is included. The auxiliary counter can act on a trigger in one of two ways: reload the core counter from its own value, or capture the core counter's value. The trigger is a chosen transition of the latch or a chosen edge of an external trigger pin.

Software reaches four 16-bit registers through a plain write strobe and a combinational read port. There are two control registers and two count registers.

Top module: `tgl_timer`

## Requirements
- R1: After synchronous reset, all four registers read 0 and `tgl_out` is 0. The addresses are 0 for core control, 1 for core count, 2 for auxiliary control and 3 for auxiliary count.
- R2: The core control fields are: bit 0 run, bits [2:1] mode (0 timer, 1 gated, 2 counter, 3 hold), bits [10:8] prescale exponent k, and bit 11 output enable. In timer mode with run set, the core count steps once every 8·2^k clocks. The first step comes 8·2^k clocks after the write that sets run.
- R3: The core counts down when bit 6 XOR (bit 7 AND the synchronized `dir_in`) is 1, and counts up otherwise.
- R4: An up step from 0xFFFF wraps to 0, and a down step from 0 wraps to 0xFFFF. Each wrap flips the toggle latch, which reads back at core control bit 15. A control write with bit 14 set loads the latch from bit 15; a control write with bit 14 clear leaves the latch alone. `tgl_out` equals the latch when bit 11 is set, and is 0 otherwise.
- R5: In gated mode the core steps on prescaler ticks only while the synchronized `cnt_in` equals core control bit 5. At any other time it holds.
- R6: In counter mode the core steps on `cnt_in` edges selected by core control bits [4:3]: 0 none, 1 rising, 2 falling, 3 both. A pin change moves the count on the third rising clock edge after the change.
- R7: A write to the core count register loads the written value and suppresses any step in that cycle. With run clear, the core count holds.
- R8: With auxiliary control bit 0 (run) set, the auxiliary count steps on latch transitions selected by bits [2:1]. Rising means the latch goes from 0 to 1. Bit 3 selects down. The step lands in the same cycle as the core wrap.
- R9: With auxiliary control bit 4 clear, a trigger reloads the core count from the auxiliary count, in place of that cycle's step or wrap value. A trigger is a latch transition selected by bits [6:5] or a synchronized `trig_in` edge selected by bits [8:7], using the same edge encoding as R6.
- R10: With auxiliary control bit 4 set, a trigger loads the auxiliary count with the core count held before that cycle.
- R11: In hold mode (mode 3) the core never steps, even with run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| cnt_in | input | 1 | External count or gate input |
| dir_in | input | 1 | External direction input |
| trig_in | input | 1 | External reload/capture trigger |
| tgl_out | output | 1 | Toggle latch output pin |

## Verification
On every cycle the assertions check four things. First, the core count moves by at most one unless it is written or reloaded. Second, a register write always wins over counting. Third, the latch changes only on a 0xFFFF/0 boundary crossing or a control write, and every up-wrap flips it. Fourth, a closed gate freezes the count. Only the bench scenarios can show the exact prescaler period for each exponent, the direction XOR, the three-clock input latency, and each edge selection. The same holds for the 32-bit chaining, the reload that lands exactly on the wrap, and capture and reload from the external trigger.

// File: rtl/tgl_timer_pkg.sv
package tgl_timer_pkg;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_CORE = 2'd1;
    localparam logic [1:0] RA_AUXC = 2'd2;
    localparam logic [1:0] RA_AUX  = 2'd3;

    localparam int LATCH_BIT  = 15;
    localparam int STROBE_BIT = 14;
    localparam int PRE_K_W    = 3;

    typedef enum logic [1:0] {
        MD_TIMER = 2'd0,
        MD_GATED = 2'd1,
        MD_COUNT = 2'd2,
        MD_HOLD  = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2,
        EV_BOTH = 2'd3
    } evsel_e;

    typedef struct packed {
        logic               run;
        tmode_e             mode;
        evsel_e             cnt_ev;
        logic               gate_lvl;
        logic               sw_down;
        logic               pin_dir_en;
        logic [PRE_K_W-1:0] pre_k;
        logic               out_en;
    } core_cfg_t;

    typedef struct packed {
        logic   run;
        evsel_e chain_ev;
        logic   down;
        logic   capture;
        evsel_e lat_trig;
        evsel_e ext_trig;
    } aux_cfg_t;

    function automatic core_cfg_t core_cfg_from(input logic [15:0] w);
        core_cfg_t c;
        c.run        = w[0];
        c.mode       = tmode_e'(w[2:1]);
        c.cnt_ev     = evsel_e'(w[4:3]);
        c.gate_lvl   = w[5];
        c.sw_down    = w[6];
        c.pin_dir_en = w[7];
        c.pre_k      = w[10:8];
        c.out_en     = w[11];
        return c;
    endfunction

    function automatic logic [15:0] core_cfg_to(input core_cfg_t c, input logic lat);
        logic [15:0] w;
        w             = '0;
        w[0]          = c.run;
        w[2:1]        = c.mode;
        w[4:3]        = c.cnt_ev;
        w[5]          = c.gate_lvl;
        w[6]          = c.sw_down;
        w[7]          = c.pin_dir_en;
        w[10:8]       = c.pre_k;
        w[11]         = c.out_en;
        w[LATCH_BIT]  = lat;
        return w;
    endfunction

    function automatic aux_cfg_t aux_cfg_from(input logic [15:0] w);
        aux_cfg_t a;
        a.run      = w[0];
        a.chain_ev = evsel_e'(w[2:1]);
        a.down     = w[3];
        a.capture  = w[4];
        a.lat_trig = evsel_e'(w[6:5]);
        a.ext_trig = evsel_e'(w[8:7]);
        return a;
    endfunction

    function automatic logic [15:0] aux_cfg_to(input aux_cfg_t a);
        logic [15:0] w;
        w      = '0;
        w[0]   = a.run;
        w[2:1] = a.chain_ev;
        w[3]   = a.down;
        w[4]   = a.capture;
        w[6:5] = a.lat_trig;
        w[8:7] = a.ext_trig;
        return w;
    endfunction

    function automatic logic ev_hit(input evsel_e sel, input logic rise, input logic fall);
        case (sel)
            EV_RISE: return rise;
            EV_FALL: return fall;
            EV_BOTH: return rise | fall;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-1:0], pin[i]};
            end
            assign lvl[i]  = sh[STAGES-1];
            assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
            assign fall[i] = ~sh[STAGES-1] & sh[STAGES];
        end
    endgenerate

endmodule

// File: rtl/tgl_prescaler.sv
module tgl_prescaler #(
    parameter int BASE_LOG = 3,
    parameter int K_W      = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [K_W-1:0] k,
    output logic           tick
);

    localparam int PRE_W = BASE_LOG + (1 << K_W) - 1;

    logic [PRE_W-1:0] acc;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    always_comb begin
        span = (PRE_W+1)'(1) << (BASE_LOG + int'(k));
        mask = PRE_W'(span - 1'b1);
    end

    assign tick = run && ((acc & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) acc <= '0;
        else             acc <= acc + 1'b1;
    end

endmodule

// File: rtl/tgl_updn_cnt.sv
module tgl_updn_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_val;
        else if (ld_en) q <= ld_val;
        else if (step)  q <= down ? q - 1'b1 : q + 1'b1;
    end

endmodule

// File: rtl/tgl_timer.sv
module tgl_timer
    import tgl_timer_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int PRE_BASE_LOG = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             cnt_in,
    input  logic             dir_in,
    input  logic             trig_in,
    output logic             tgl_out
);

    localparam int PIN_N  = 3;
    localparam int P_CNT  = 0;
    localparam int P_DIR  = 1;
    localparam int P_TRIG = 2;

    core_cfg_t core_cfg;
    aux_cfg_t  aux_cfg;
    logic      latch_q;

    logic [PIN_N-1:0] pin_lvl, pin_rise, pin_fall;
    logic             tick;
    logic [CNT_W-1:0] core_q, aux_q;

    logic wr_ctrl, wr_core, wr_auxc, wr_aux;
    logic dir_down, gate_open, core_step, wrap;
    logic lat_rise, lat_fall, trig, reload_fire, capture_fire, aux_step;

    // input synchronizers with edge history
    tgl_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  ({trig_in, dir_in, cnt_in}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    tgl_prescaler #(.BASE_LOG(PRE_BASE_LOG), .K_W(PRE_K_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (core_cfg.run),
        .k    (core_cfg.pre_k),
        .tick (tick)
    );

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
        wr_core = bus_wr && (bus_addr == RA_CORE);
        wr_auxc = bus_wr && (bus_addr == RA_AUXC);
        wr_aux  = bus_wr && (bus_addr == RA_AUX);
    end

    // step qualification per mode
    always_comb begin
        dir_down  = core_cfg.sw_down ^ (core_cfg.pin_dir_en & pin_lvl[P_DIR]);
        gate_open = (pin_lvl[P_CNT] == core_cfg.gate_lvl);
        case (core_cfg.mode)
            MD_TIMER: core_step = core_cfg.run && tick;
            MD_GATED: core_step = core_cfg.run && tick && gate_open;
            MD_COUNT: core_step = core_cfg.run &&
                                  ev_hit(core_cfg.cnt_ev, pin_rise[P_CNT], pin_fall[P_CNT]);
            default:  core_step = 1'b0;
        endcase
    end

    // wrap event, taken from the next-state view so reload and chaining land on the wrap edge
    always_comb begin
        wrap         = core_step && !wr_core &&
                       (dir_down ? (core_q == '0) : (&core_q));
        lat_rise     = wrap && !latch_q;
        lat_fall     = wrap &&  latch_q;
        trig         = ev_hit(aux_cfg.lat_trig, lat_rise, lat_fall) ||
                       ev_hit(aux_cfg.ext_trig, pin_rise[P_TRIG], pin_fall[P_TRIG]);
        reload_fire  = trig && !aux_cfg.capture;
        capture_fire = trig &&  aux_cfg.capture;
        aux_step     = aux_cfg.run && ev_hit(aux_cfg.chain_ev, lat_rise, lat_fall);
    end

    tgl_updn_cnt #(.W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_core),
        .wr_val (bus_wdata),
        .ld_en  (reload_fire),
        .ld_val (aux_q),
        .step   (core_step),
        .down   (dir_down),
        .q      (core_q)
    );

    tgl_updn_cnt #(.W(CNT_W)) u_aux (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_aux),
        .wr_val (bus_wdata),
        .ld_en  (capture_fire),
        .ld_val (core_q),
        .step   (aux_step),
        .down   (aux_cfg.down),
        .q      (aux_q)
    );

    // control registers and toggle latch
    always_ff @(posedge clk) begin
        if (rst) begin
            core_cfg <= '0;
            aux_cfg  <= '0;
            latch_q  <= 1'b0;
        end else begin
            if (wr_ctrl) core_cfg <= core_cfg_from(bus_wdata[15:0]);
            if (wr_auxc) aux_cfg  <= aux_cfg_from(bus_wdata[15:0]);
            if (wr_ctrl && bus_wdata[STROBE_BIT]) latch_q <= bus_wdata[LATCH_BIT];
            else if (wrap)                        latch_q <= ~latch_q;
        end
    end

    always_comb begin
        case (bus_addr)
            RA_CTRL: bus_rdata = CNT_W'(core_cfg_to(core_cfg, latch_q));
            RA_CORE: bus_rdata = core_q;
            RA_AUXC: bus_rdata = CNT_W'(aux_cfg_to(aux_cfg));
            default: bus_rdata = aux_q;
        endcase
    end

    assign tgl_out = core_cfg.out_en & latch_q;

endmodule

// File: rtl/tgl_timer_chk.sv
module tgl_timer_chk
    import tgl_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] core_q,
    input logic             latch_q,
    input logic             run,
    input tmode_e           mode,
    input logic             gate_open,
    input logic             reload_fire
);

    logic wr_core_c, wr_ctrl_c;
    assign wr_core_c = bus_wr && (bus_addr == RA_CORE);
    assign wr_ctrl_c = bus_wr && (bus_addr == RA_CTRL);

    AST_CORE_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_core_c |=> core_q == $past(bus_wdata)); // R7

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_core_c && !reload_fire) |=> $stable(core_q)); // R7

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (!wr_core_c && !reload_fire) |=>
            (core_q == $past(core_q)) ||
            (core_q == CNT_W'($past(core_q) + 1'b1)) ||
            (core_q == CNT_W'($past(core_q) - 1'b1))); // R2

    AST_LATCH_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        ((latch_q != $past(latch_q)) && !$past(wr_ctrl_c)) |->
            (($past(core_q) == {CNT_W{1'b1}}) || ($past(core_q) == '0))); // R4

    AST_UP_WRAP_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (($past(core_q) == {CNT_W{1'b1}}) && (core_q == '0) &&
         !$past(bus_wr) && !$past(reload_fire)) |-> (latch_q != $past(latch_q))); // R4

    AST_GATE_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (run && (mode == MD_GATED) && !gate_open && !wr_core_c && !reload_fire)
            |=> $stable(core_q)); // R5

endmodule

bind tgl_timer tgl_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .core_q      (core_q),
    .latch_q     (latch_q),
    .run         (core_cfg.run),
    .mode        (core_cfg.mode),
    .gate_open   (gate_open),
    .reload_fire (reload_fire)
);

// File: tb/tgl_timer_bench.sv
module tgl_timer_bench;
    import tgl_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cnt_in = 1'b0;
    logic        dir_in = 1'b0;
    logic        trig_in = 1'b0;
    logic        tgl_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tgl_timer u_tgl_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
        .dir_in(dir_in), .trig_in(trig_in), .tgl_out(tgl_out)
    );

    // timer-mode vectors: stimulus and expected result
    typedef struct packed {
        logic [2:0]  k;
        logic        sw_dn;
        logic        pin_en;
        logic        pin;
        logic [15:0] start;
        logic [15:0] n;
        logic [15:0] exp_cnt;
        logic        exp_lat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd79,  16'h000A, 1'b0},
        '{3'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd159, 16'h000A, 1'b0},
        '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0005, 16'd47,  16'hFFFF, 1'b1},
        '{3'd0, 1'b0, 1'b0, 1'b0, 16'hFFFE, 16'd23,  16'h0001, 1'b1},
        '{3'd2, 1'b0, 1'b0, 1'b0, 16'h0064, 16'd95,  16'h0067, 1'b0},
        '{3'd0, 1'b1, 1'b1, 1'b1, 16'h000A, 16'd15,  16'h000C, 1'b0},
        '{3'd0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'd7,   16'hFFFF, 1'b1}
    };

    function automatic logic [15:0] mk_ctrl(input logic run, input logic [1:0] mode,
            input logic [1:0] ev, input logic gate, input logic sw_dn, input logic pin_en,
            input logic [2:0] k, input logic out_en, input logic strobe, input logic lat);
        return {lat, strobe, 2'b00, out_en, k, pin_en, sw_dn, gate, ev, mode, run};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_cnt(input int c);
        for (int i = 0; i < c; i++) begin
            cnt_in = 1'b0; repeat (2) @(negedge clk);
            cnt_in = 1'b1; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1; repeat (3) @(negedge clk);
        trig_in = 1'b0; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] c;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), rd);
            check("R1 reset register", rd, 16'h0000);
        end
        check("R1 reset tgl_out", {15'd0, tgl_out}, 16'h0000);

        // R2 R3 R4 timer-mode vector table
        for (int v = 0; v < NV; v++) begin
            dir_in = VECS[v].pin;
            bus_write(RA_CORE, VECS[v].start);
            c = mk_ctrl(1'b1, 2'd0, 2'd0, 1'b0, VECS[v].sw_dn, VECS[v].pin_en,
                        VECS[v].k, 1'b1, 1'b1, 1'b0);
            bus_write(RA_CTRL, c);
            wait_clks(int'(VECS[v].n));
            c[0] = 1'b0; c[STROBE_BIT] = 1'b0;
            bus_write(RA_CTRL, c);
            bus_read(RA_CORE, rd);
            check("R2/R3 timer count", rd, VECS[v].exp_cnt);
            bus_read(RA_CTRL, rd);
            check("R4 latch after run", {15'd0, rd[15]}, {15'd0, VECS[v].exp_lat});
            check("R4 tgl_out follows latch", {15'd0, tgl_out}, {15'd0, VECS[v].exp_lat});
        end
        dir_in = 1'b0;

        // R4 output enable and latch strobe
        bus_write(RA_CTRL, mk_ctrl(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1));
        check("R4 out disabled", {15'd0, tgl_out}, 16'h0000);
        bus_read(RA_CTRL, rd);
        check("R4 latch strobe load", {15'd0, rd[15]}, 16'h0001);
        bus_write(RA_CTRL, mk_ctrl(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0));
        check("R4 out enabled, latch kept", {15'd0, tgl_out}, 16'h0001);

        // R7 write wins over a step in the same cycle, then hold with run clear
        bus_write(RA_CORE, 16'h0000);
        bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        wait_clks(7);
        bus_write(RA_CORE, 16'h1234);
        bus_read(RA_CORE, rd);
        check("R7 write over tick", rd, 16'h1234);
        wait_clks(8);
        @(negedge clk);
        bus_read(RA_CORE, rd);
        check("R7 next tick after write", rd, 16'h1235);
        bus_write(RA_CTRL, mk_ctrl(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        wait_clks(40);
        @(negedge clk);
        bus_read(RA_CORE, rd);
        check("R7 hold with run clear", rd, 16'h1235);

        // R5 gated mode
        cnt_in = 1'b0;
        bus_write(RA_CORE, 16'h0000);
        bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        wait_clks(39);
        bus_write(RA_CTRL, mk_ctrl(1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        bus_read(RA_CORE, rd);
        check("R5 gate closed", rd, 16'h0000);
        cnt_in = 1'b1;
        bus_write(RA_CORE, 16'h0000);
        bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        wait_clks(39);
        bus_write(RA_CTRL, mk_ctrl(1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        bus_read(RA_CORE, rd);
        check("R5 gate open", rd, 16'h0005);

        // R6 counter mode: latency and edge selections
        cnt_in = 1'b0;
        bus_write(RA_CORE, 16'h0000);
        bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        cnt_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_read(RA_CORE, rd);
        check("R6 no step before third edge", rd, 16'h0000);
        @(posedge clk); @(negedge clk);
        bus_read(RA_CORE, rd);
        check("R6 step on third edge", rd, 16'h0001);
        for (int e = 0; e < 4; e++) begin
            bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd2, 2'(e), 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
            bus_write(RA_CORE, 16'h0000);
            pulse_cnt(4);
            bus_read(RA_CORE, rd);
            check("R6 edge select count", rd, (e == 0) ? 16'd0 : (e == 3) ? 16'd8 : 16'd4);
        end
        cnt_in = 1'b0;

        // R8 chained auxiliary counter
        bus_write(RA_AUXC, 16'h0007);
        bus_write(RA_AUX, 16'h0007);
        bus_write(RA_CORE, 16'hFFFD);
        bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0));
        wait_clks(23);
        bus_write(RA_CTRL, mk_ctrl(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        bus_read(RA_CORE, rd);
        check("R8 core wrapped", rd, 16'h0000);
        bus_read(RA_AUX, rd);
        check("R8 aux carried", rd, 16'h0008);

        // R9 reload on latch transition, landing on the wrap
        bus_write(RA_AUXC, 16'h0060);
        bus_write(RA_AUX, 16'hFFF0);
        bus_write(RA_CORE, 16'hFFFE);
        bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0));
        wait_clks(39);
        bus_write(RA_CTRL, mk_ctrl(1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        bus_read(RA_CORE, rd);
        check("R9 reload on wrap", rd, 16'hFFF3);
        bus_read(RA_CTRL, rd);
        check("R9 latch flipped on reload wrap", {15'd0, rd[15]}, 16'h0001);

        // R11 hold mode, then R9 reload from external trigger
        bus_write(RA_AUXC, 16'h0080);
        bus_write(RA_AUX, 16'h4321);
        bus_write(RA_CORE, 16'h0000);
        bus_write(RA_CTRL, mk_ctrl(1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0));
        wait_clks(40);
        @(negedge clk);
        bus_read(RA_CORE, rd);
        check("R11 hold mode no step", rd, 16'h0000);
        pulse_trig();
        bus_read(RA_CORE, rd);
        check("R9 external reload", rd, 16'h4321);

        // R10 capture from external trigger
        bus_write(RA_AUXC, 16'h0090);
        bus_write(RA_CORE, 16'hBEEF);
        bus_write(RA_AUX, 16'h0000);
        pulse_trig();
        bus_read(RA_AUX, rd);
        check("R10 capture core into aux", rd, 16'hBEEF);
        bus_read(RA_CORE, rd);
        check("R10 core unchanged by capture", rd, 16'hBEEF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule